// File: doc/BRIEF.md
# Block memory micro-op sequencer

This block turns one accepted block-memory instruction into a stream of micro-operations. A block transfer is split into eight steps and a paired (twin) load into two. For every step the sequencer produces the effective address, the destination register index, the half of a register pair being written, the transfer direction and a commit marker. The marker is delayed-commit for intermediate steps and last for the final step.

The address base is the first source operand plus either the second source operand or a sign-extended 13-bit immediate. That sum is formed once at accept time. Each step then adds eight bytes per step number. Privilege and alignment checks are made on the first step only, and alignment has the higher priority. A faulting first step is emitted alone, marked last, and the sequence ends there.

The controller has two states. IDLE accepts an instruction, which is the ACCEPT transition into EMIT. EMIT presents one micro-op per handshake. On a handshake for a non-final step it takes STEP and stays in EMIT. On a handshake for the final step, or for a faulting first step, it takes FINISH back to IDLE. With no ready it takes STALL and holds every output.

Top module: `bmseq_top`

## Requirements
- R1: In block mode (in_twin=0) an accepted instruction produces exactly 8 micro-ops with uop_index 0,1,...,7 in order, after which the block returns to IDLE (in_ready=1).
- R2: In twin mode (in_twin=1) an accepted instruction produces exactly 2 micro-ops with uop_index 0 and 1.
- R3: In register form (in_use_imm=0) uop_addr of step n equals in_rs1 + in_rs2 + 8*n, modulo 2^32.
- R4: In immediate form (in_use_imm=1) uop_addr of step n equals in_rs1 + sext(in_imm) + 8*n, where in_imm[12] is the sign bit.
- R5: While uop_valid=1, the final step (index 7 in block mode, 1 in twin mode) has uop_last=1 and uop_delayed=0, and every earlier step has uop_last=0 and uop_delayed=1.
- R6: uop_reg of step n equals in_frd + n (5-bit wrap). uop_pair_hi is 1 only on step 1 of twin mode and 0 everywhere else.
- R7: uop_fault is checked on step 0 only, with encoding 0 = none, 1 = privilege, 2 = alignment. The alignment fault is raised when uop_addr[5:0]!=0 in block mode or uop_addr[3:0]!=0 in twin mode. The privilege fault is raised when in_asi_restricted=1 and in_priv=0.
- R8: When both fault conditions hold on step 0, uop_fault is 2 (alignment).
- R9: A faulting step 0 is emitted as the only micro-op, with uop_last=1 and uop_delayed=0, and the block then returns to IDLE.
- R10: in_ready is 1 only in IDLE, and in_valid while emitting has no effect. While uop_valid=1 and uop_ready=0 all uop outputs stay unchanged, and the step advances only on uop_valid and uop_ready.
- R11: Direction, form, operands, destination and privilege inputs are sampled at accept. Changing them during the sequence does not alter any micro-op, and uop_store equals in_store as it was at accept.
- R12: After reset the block is in IDLE with in_ready=1 and uop_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Sequencer idle, instruction taken on in_valid |
| in_twin | input | 1 | 0 = block mode (8 steps), 1 = twin mode (2 steps) |
| in_store | input | 1 | Transfer direction, 1 = store |
| in_use_imm | input | 1 | 1 = immediate form, 0 = register form |
| in_imm | input | 13 | Low 13 bits of the instruction word |
| in_rs1 | input | 32 | Base operand |
| in_rs2 | input | 32 | Second operand for register form |
| in_frd | input | 5 | Destination register base index |
| in_asi_restricted | input | 1 | Selected alternate space requires privilege |
| in_priv | input | 1 | Issuing context is privileged |
| uop_valid | output | 1 | Micro-op presented |
| uop_ready | input | 1 | Consumer takes the micro-op |
| uop_addr | output | 32 | Effective address of the step |
| uop_index | output | 3 | Step number |
| uop_reg | output | 5 | Destination register index of the step |
| uop_pair_hi | output | 1 | High half of the register pair (twin step 1) |
| uop_store | output | 1 | Latched direction |
| uop_last | output | 1 | Final micro-op of the sequence |
| uop_delayed | output | 1 | Intermediate micro-op, commit delayed |
| uop_fault | output | 2 | Fault code of step 0 (0 none, 1 privilege, 2 alignment) |

## Verification
Block and twin instructions are issued in both register and immediate form. The immediate form uses a negative immediate, which separates true sign extension from zero extension. One base is aligned to 16 bytes but not to 64, which separates the block alignment rule from the twin one. Privilege-only, alignment-only and both-fault cases expose the fault priority and the early end of a sequence. A privileged access to a restricted space confirms that no fault is raised falsely. The consumer's ready is held high, toggled and throttled, so that stalls can be told apart from steps. Inputs are scrambled and in_valid is raised while busy, which shows whether anything is sampled after accept.

// File: rtl/bmseq_pkg.sv
package bmseq_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_PRIV  = 2'd1,
        FLT_ALIGN = 2'd2
    } fault_e;

    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } state_e;

    typedef struct packed {
        logic twin;
        logic store;
        logic restricted;
        logic priv;
    } ctl_s;
endpackage

// File: rtl/bmseq_agen.sv
module bmseq_agen #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 13,
    parameter int IDX_W      = 3,
    parameter int STEP_BYTES = 8
) (
    input  logic [ADDR_W-1:0] rs1,
    input  logic [ADDR_W-1:0] rs2,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] base_sum,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] imm_x;

    generate
        if (ADDR_W > IMM_W) begin : g_sext
            assign imm_x = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_x = imm[ADDR_W-1:0];
        end
    endgenerate

    // Base is formed once at accept; each step only adds its offset.
    assign base_sum = rs1 + (use_imm ? imm_x : rs2);
    assign ea       = base_q + (ADDR_W'(idx) * ADDR_W'(STEP_BYTES));
endmodule

// File: rtl/bmseq_fault.sv
module bmseq_fault
    import bmseq_pkg::*;
#(
    parameter int BLOCK_ALIGN_BITS = 6,
    parameter int TWIN_ALIGN_BITS  = 4
) (
    input  logic [BLOCK_ALIGN_BITS-1:0] ea_low,
    input  logic                        twin,
    input  logic                        first,
    input  logic                        restricted,
    input  logic                        priv,
    output fault_e                      code,
    output logic                        hit
);
    logic misaligned;
    logic priv_bad;

    always_comb begin
        misaligned = twin ? (ea_low[TWIN_ALIGN_BITS-1:0] != '0) : (ea_low != '0);
        priv_bad   = restricted && !priv;
        code       = FLT_NONE;
        if (first) begin
            // alignment outranks privilege
            if (misaligned)    code = FLT_ALIGN;
            else if (priv_bad) code = FLT_PRIV;
        end
        hit = (code != FLT_NONE);
    end
endmodule

// File: rtl/bmseq_fsm.sv
module bmseq_fsm
    import bmseq_pkg::*;
#(
    parameter int BLOCK_STEPS = 8,
    parameter int TWIN_STEPS  = 2,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             twin,
    input  logic             fault_hit,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             accept,
    output logic             is_last,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] BLK_LAST = IDX_W'(BLOCK_STEPS - 1);
    localparam logic [IDX_W-1:0] TWN_LAST = IDX_W'(TWIN_STEPS - 1);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        accept    = in_ready && in_valid;
        is_last   = out_valid && (fault_hit || (idx_q == (twin ? TWN_LAST : BLK_LAST)));
        idx       = idx_q;
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin          // ACCEPT
                    state_d = ST_EMIT;
                    idx_d   = '0;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (is_last) state_d = ST_IDLE;   // FINISH
                    else         idx_d   = idx_q + 1'b1; // STEP
                end
            end
        endcase
    end

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(idx_q)));
    assert_step_adv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !is_last) |=> (idx_q == $past(idx_q) + 1'b1));
    assert_end_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && is_last) |=> in_ready);
endmodule

// File: rtl/bmseq_top.sv
module bmseq_top
    import bmseq_pkg::*;
#(
    parameter int ADDR_W           = 32,
    parameter int IMM_W            = 13,
    parameter int REG_W            = 5,
    parameter int BLOCK_STEPS      = 8,
    parameter int TWIN_STEPS       = 2,
    parameter int STEP_BYTES       = 8,
    parameter int BLOCK_ALIGN_BITS = 6,
    parameter int TWIN_ALIGN_BITS  = 4,
    localparam int IDX_W           = $clog2(BLOCK_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_twin,
    input  logic              in_store,
    input  logic              in_use_imm,
    input  logic [IMM_W-1:0]  in_imm,
    input  logic [ADDR_W-1:0] in_rs1,
    input  logic [ADDR_W-1:0] in_rs2,
    input  logic [REG_W-1:0]  in_frd,
    input  logic              in_asi_restricted,
    input  logic              in_priv,
    output logic              uop_valid,
    input  logic              uop_ready,
    output logic [ADDR_W-1:0] uop_addr,
    output logic [IDX_W-1:0]  uop_index,
    output logic [REG_W-1:0]  uop_reg,
    output logic              uop_pair_hi,
    output logic              uop_store,
    output logic              uop_last,
    output logic              uop_delayed,
    output logic [1:0]        uop_fault
);
    localparam logic [IDX_W-1:0] TWN_LAST = IDX_W'(TWIN_STEPS - 1);

    logic [ADDR_W-1:0] base_q, base_sum, ea;
    logic [REG_W-1:0]  frd_q;
    ctl_s              ctl_q;
    logic              accept, is_last, fault_hit, valid;
    logic [IDX_W-1:0]  idx;
    fault_e            fcode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            frd_q  <= '0;
            ctl_q  <= '0;
        end else if (accept) begin
            base_q <= base_sum;
            frd_q  <= in_frd;
            ctl_q  <= '{twin: in_twin, store: in_store,
                        restricted: in_asi_restricted, priv: in_priv};
        end
    end

    bmseq_agen #(
        .ADDR_W(ADDR_W), .IMM_W(IMM_W), .IDX_W(IDX_W), .STEP_BYTES(STEP_BYTES)
    ) u_agen (
        .rs1(in_rs1), .rs2(in_rs2), .imm(in_imm), .use_imm(in_use_imm),
        .base_q(base_q), .idx(idx), .base_sum(base_sum), .ea(ea)
    );

    bmseq_fault #(
        .BLOCK_ALIGN_BITS(BLOCK_ALIGN_BITS), .TWIN_ALIGN_BITS(TWIN_ALIGN_BITS)
    ) u_fault (
        .ea_low(ea[BLOCK_ALIGN_BITS-1:0]), .twin(ctl_q.twin),
        .first(valid && (idx == '0)), .restricted(ctl_q.restricted),
        .priv(ctl_q.priv), .code(fcode), .hit(fault_hit)
    );

    bmseq_fsm #(
        .BLOCK_STEPS(BLOCK_STEPS), .TWIN_STEPS(TWIN_STEPS), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .twin(ctl_q.twin),
        .fault_hit(fault_hit), .out_ready(uop_ready), .in_ready(in_ready),
        .out_valid(valid), .accept(accept), .is_last(is_last), .idx(idx)
    );

    always_comb begin
        uop_valid   = valid;
        uop_addr    = ea;
        uop_index   = idx;
        uop_reg     = frd_q + REG_W'(idx);
        uop_pair_hi = valid && ctl_q.twin && (idx == TWN_LAST);
        uop_store   = ctl_q.store;
        uop_last    = is_last;
        uop_delayed = valid && !is_last;
        uop_fault   = fcode;
    end

    assert_fault_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_fault != 2'd0) |-> (uop_index == '0 && uop_last));
    assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (uop_last != uop_delayed));
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !uop_ready) |=> ($stable(uop_addr) && $stable(uop_reg) && $stable(uop_fault)));
    assert_dir_fixed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && !(uop_ready && uop_last)) |=> $stable(uop_store));
endmodule

// File: tb/bmseq_top_test.sv
module bmseq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_twin = 1'b0, in_store = 1'b0, in_use_imm = 1'b0;
    logic [12:0] in_imm = '0;
    logic [31:0] in_rs1 = '0, in_rs2 = '0;
    logic [4:0]  in_frd = '0;
    logic        in_asi_restricted = 1'b0, in_priv = 1'b0;
    logic        uop_ready = 1'b0;
    logic        in_ready, uop_valid, uop_pair_hi, uop_store, uop_last, uop_delayed;
    logic [31:0] uop_addr;
    logic [2:0]  uop_index;
    logic [4:0]  uop_reg;
    logic [1:0]  uop_fault;

    int total = 0;
    int bad = 0;
    int bp_mode = 0;
    int bp_ctr = 0;
    int cycles = 0;

    typedef struct {
        logic [31:0] addr;
        logic [2:0]  idx;
        logic [4:0]  rg;
        logic        hi, store, last, dly;
        logic [1:0]  flt;
        string       tag;
    } exp_t;
    exp_t q[$];

    bmseq_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_twin(in_twin), .in_store(in_store), .in_use_imm(in_use_imm),
        .in_imm(in_imm), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_frd(in_frd),
        .in_asi_restricted(in_asi_restricted), .in_priv(in_priv),
        .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_addr(uop_addr),
        .uop_index(uop_index), .uop_reg(uop_reg), .uop_pair_hi(uop_pair_hi),
        .uop_store(uop_store), .uop_last(uop_last), .uop_delayed(uop_delayed),
        .uop_fault(uop_fault)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: compute expected items from the requirements and offer the instruction.
    task automatic issue(input logic twin, input logic store, input logic use_imm,
                         input logic [12:0] imm, input logic [31:0] rs1, input logic [31:0] rs2,
                         input logic [4:0] frd, input logic restr, input logic priv,
                         input bit poke, input string tag);
        logic [31:0] base;
        logic [1:0]  flt;
        int          steps;
        exp_t        e;
        base  = rs1 + (use_imm ? {{19{imm[12]}}, imm} : rs2);
        steps = twin ? 2 : 8;
        if (twin ? (base[3:0] != 0) : (base[5:0] != 0)) flt = 2'd2;
        else if (restr && !priv)                        flt = 2'd1;
        else                                            flt = 2'd0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        for (int n = 0; n < steps; n++) begin
            e.addr  = base + 32'(n * 8);
            e.idx   = 3'(n);
            e.rg    = frd + 5'(n);
            e.hi    = twin && (n == 1);
            e.store = store;
            e.last  = (flt != 0) || (n == steps - 1);
            e.dly   = !e.last;
            e.flt   = (n == 0) ? flt : 2'd0;
            e.tag   = tag;
            q.push_back(e);
            if (flt != 0) break;
        end
        in_twin = twin; in_store = store; in_use_imm = use_imm; in_imm = imm;
        in_rs1 = rs1; in_rs2 = rs2; in_frd = frd;
        in_asi_restricted = restr; in_priv = priv;
        in_valid = 1'b1;
        @(negedge clk);
        // R11: scramble everything after accept
        in_twin = ~twin; in_store = ~store; in_use_imm = ~use_imm; in_imm = ~imm;
        in_rs1 = ~rs1; in_rs2 = rs2 + 32'h123; in_frd = ~frd;
        in_asi_restricted = ~restr; in_priv = ~priv;
        in_valid = poke;  // R10: offering while busy must have no effect
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
        end else begin
            in_valid = 1'b0;
        end
    endtask

    // Monitor: drive the consumer ready, then pop and compare.
    logic        stalled = 1'b0;
    logic [31:0] snap_addr;
    logic [4:0]  snap_reg;
    logic [2:0]  snap_idx;
    always @(negedge clk) begin
        if (rst_n) begin
            bp_ctr++;
            case (bp_mode)
                0: uop_ready = 1'b1;
                1: uop_ready = bp_ctr[0];
                default: uop_ready = (bp_ctr % 3) == 0;
            endcase
            #1;
            if (stalled) begin
                check("R10", "stall addr", uop_addr, snap_addr);
                check("R10", "stall reg", {27'd0, uop_reg}, {27'd0, snap_reg});
                check("R10", "stall index", {29'd0, uop_index}, {29'd0, snap_idx});
            end
            stalled = 1'b0;
            if (uop_valid) begin
                check("R10", "in_ready while busy", {31'd0, in_ready}, 32'd0);
                if (uop_ready) begin
                    if (q.size() == 0) begin
                        check("R1", "unexpected micro-op", 32'd1, 32'd0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(e.tag, "R3/R4 addr", uop_addr, e.addr);
                        check(e.tag, "R1 index", {29'd0, uop_index}, {29'd0, e.idx});
                        check(e.tag, "R6 reg", {27'd0, uop_reg}, {27'd0, e.rg});
                        check(e.tag, "R6 pair_hi", {31'd0, uop_pair_hi}, {31'd0, e.hi});
                        check(e.tag, "R11 store", {31'd0, uop_store}, {31'd0, e.store});
                        check(e.tag, "R5 last", {31'd0, uop_last}, {31'd0, e.last});
                        check(e.tag, "R5 delayed", {31'd0, uop_delayed}, {31'd0, e.dly});
                        check(e.tag, "R7 fault", {30'd0, uop_fault}, {30'd0, e.flt});
                    end
                end else begin
                    stalled   = 1'b1;
                    snap_addr = uop_addr;
                    snap_reg  = uop_reg;
                    snap_idx  = uop_index;
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic drain();
        @(negedge clk);
        while (q.size() != 0 || !in_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12", "reset in_ready", {31'd0, in_ready}, 32'd1);
        check("R12", "reset uop_valid", {31'd0, uop_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "idle in_ready", {31'd0, in_ready}, 32'd1);

        bp_mode = 0;
        issue(0, 0, 0, 13'h0, 32'h1000_0000, 32'h40, 5'd4, 0, 0, 0, "R1 R3 block reg");
        drain();
        bp_mode = 1;
        issue(0, 1, 1, 13'h1FC0, 32'h2000_0100, 32'h7, 5'd30, 0, 0, 0, "R4 block negative imm");
        drain();
        issue(1, 0, 0, 13'h0, 32'h3000_0000, 32'h10, 5'd8, 0, 0, 0, "R2 twin reg");
        drain();
        bp_mode = 2;
        issue(1, 1, 1, 13'h0FF0, 32'h100, 32'h3, 5'd2, 0, 0, 0, "R2 R4 twin imm");
        drain();
        issue(0, 0, 0, 13'h0, 32'h4000_0000, 32'h10, 5'd0, 0, 0, 0, "R7 R9 block align");
        drain();
        bp_mode = 1;
        issue(1, 0, 1, 13'h8, 32'h5000_0000, 32'h0, 5'd6, 0, 0, 0, "R7 R9 twin align");
        drain();
        issue(0, 1, 0, 13'h0, 32'h6000_0000, 32'h80, 5'd1, 1, 0, 0, "R7 R9 priv");
        drain();
        issue(0, 0, 0, 13'h0, 32'h7000_0004, 32'h0, 5'd1, 1, 0, 0, "R8 both faults");
        drain();
        bp_mode = 0;
        issue(1, 1, 0, 13'h0, 32'h8000_0000, 32'h20, 5'd10, 1, 1, 0, "R7 priv granted");
        drain();
        bp_mode = 2;
        issue(0, 1, 0, 13'h0, 32'hFFFF_FFC0, 32'h0, 5'd28, 0, 0, 1, "R10 R11 busy poke");
        drain();
        bp_mode = 0;
        issue(0, 0, 1, 13'h1000, 32'h0000_2000, 32'h0, 5'd0, 0, 0, 0, "R4 min imm");
        drain();

        repeat (10) @(negedge clk);
        check("R1", "queue empty at end", 32'(q.size()), 32'd0);
        check("R1", "final in_ready", {31'd0, in_ready}, 32'd1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule